// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands of parameterized width `WIDTH` (32 by default) over several clock cycles. Each cycle it recodes one multiplier bit with radix-2 Booth pairs, so only one `WIDTH`-wide adder/subtractor is needed. That unit works on the upper half of a shifting product register. The result is the full double-width signed product.

To use it, a client drives both operands and pulses `start` for one cycle while the block is idle. The block raises `busy` for exactly `WIDTH` cycles. It then gives a one-cycle `done` pulse, and in that same cycle the new product appears on `product`. The product is held until the next operation completes. A `start` pulse is accepted in the `done` cycle, so operations can run back to back.

Top module: `booth_seq_mul`

## Requirements
- R1: While `rst` is high and after it is released, `busy` and `done` are 0 and `product` is all zeros until the first operation completes.
- R2: A `start` sampled high while `busy` is low captures `mcand` and `mplier` at that edge. `busy` is then high for exactly `WIDTH` consecutive cycles.
- R3: `done` is high for exactly one cycle. It rises at the same edge where `busy` falls, one cycle after the last of the `WIDTH` iterations.
- R4: In the `done` cycle, `product` equals the signed product of the captured operands as a `2*WIDTH`-bit two's-complement value (for example 2 × -3 gives -6).
- R5: Each iteration looks at the pair (current multiplier LSB, previous bit). Pair 10 subtracts the multiplicand from the upper half and pair 01 adds it. Pairs 00 and 11 leave it unchanged. The whole register then shifts right by one with the sign bit copied. The previous bit starts at 0 and the upper half starts at 0.
- R6: The most negative operand times the most negative operand gives +2^(2*WIDTH-2), with no overflow of the upper half.
- R7: A `start` pulse while `busy` is high is ignored. It changes neither the result nor the number of busy cycles.
- R8: Changes on `mcand` and `mplier` after the capture edge have no effect on the running operation.
- R9: `product` changes only at the edge where `done` rises. It holds its value through idle cycles and through the whole of the next operation.
- R10: A `start` given in the `done` cycle is accepted, and `busy` rises at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a multiplication |
| mcand | input | WIDTH | Signed multiplicand |
| mplier | input | WIDTH | Signed multiplier |
| busy | output | 1 | High while iterations are running |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2*WIDTH | Signed double-width result |

## Verification
Directed operands cover zero, ±1, the two extreme values in every combination, and the small 2 × -3 case. Multiplier patterns of alternating bits make the add/subtract choice flip every iteration. Long runs of ones exercise the no-operation pairs and the sign-copying shift. Seeded random operands then mix all four Booth pairs. Extra runs inject a `start` mid-operation, scramble the operand inputs after capture, and issue back-to-back starts. These show apart operand capture, start masking, busy length and product holding.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1
  } booth_state_t;

  typedef enum logic [1:0] {
    OP_KEEP = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } booth_op_t;

  // Radix-2 recoding of (current bit, previous bit)
  function automatic booth_op_t booth_decode(input logic cur, input logic prev);
    booth_op_t op;
    case ({cur, prev})
      2'b10:   op = OP_SUB;
      2'b01:   op = OP_ADD;
      default: op = OP_KEEP;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic last,
  output logic busy,
  output logic done
);
  import booth_pkg::*;

  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(WIDTH - 1);

  booth_state_t state_q;
  logic [CW-1:0] iter_q;
  logic          done_q;

  assign busy = (state_q == ST_RUN);
  assign load = start && (state_q == ST_IDLE);
  assign step = busy;
  assign last = busy && (iter_q == LAST_IDX);
  assign done = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      iter_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_RUN;
            iter_q  <= '0;
          end
        end
        ST_RUN: begin
          iter_q <= iter_q + 1'b1;
          if (iter_q == LAST_IDX) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH:0]   acc,
  input  logic [WIDTH-1:0] mcand,
  input  logic             sub,
  output logic [WIDTH:0]   sum
);
  logic [WIDTH:0] ext;
  logic [WIDTH:0] opnd;

  assign ext  = {mcand[WIDTH-1], mcand};
  assign opnd = ext ^ {(WIDTH+1){sub}};
  assign sum  = acc + opnd + {{WIDTH{1'b0}}, sub};

endmodule

// File: rtl/booth_datapath.sv
module booth_datapath #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               step,
  input  logic [WIDTH-1:0]   mcand_in,
  input  logic [WIDTH-1:0]   mplier_in,
  output logic [2*WIDTH-1:0] next_result
);
  import booth_pkg::*;

  // upper half carries one guard bit so min*min stays in range
  logic [WIDTH:0]   hi_q;
  logic [WIDTH-1:0] lo_q;
  logic             prev_q;
  logic [WIDTH-1:0] mcand_q;

  booth_op_t        op;
  logic [WIDTH:0]   sum;
  logic [WIDTH:0]   hi_upd;
  logic [WIDTH:0]   hi_shift;
  logic [WIDTH-1:0] lo_shift;

  assign op = booth_decode(lo_q[0], prev_q);

  booth_addsub #(.WIDTH(WIDTH)) u_addsub (
    .acc   (hi_q),
    .mcand (mcand_q),
    .sub   (op == OP_SUB),
    .sum   (sum)
  );

  assign hi_upd   = (op == OP_KEEP) ? hi_q : sum;
  assign hi_shift = {hi_upd[WIDTH], hi_upd[WIDTH:1]};
  assign lo_shift = {hi_upd[0], lo_q[WIDTH-1:1]};
  assign next_result = {hi_shift[WIDTH-1:0], lo_shift};

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q    <= '0;
      lo_q    <= '0;
      prev_q  <= 1'b0;
      mcand_q <= '0;
    end else if (load) begin
      hi_q    <= '0;
      lo_q    <= mplier_in;
      prev_q  <= 1'b0;
      mcand_q <= mcand_in;
    end else if (step) begin
      hi_q    <= hi_shift;
      lo_q    <= lo_shift;
      prev_q  <= lo_q[0];
    end
  end

endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  logic load, step, last;
  logic [2*WIDTH-1:0] next_result;
  logic [2*WIDTH-1:0] product_q;

  booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .load  (load),
    .step  (step),
    .last  (last),
    .busy  (busy),
    .done  (done)
  );

  booth_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .load        (load),
    .step        (step),
    .mcand_in    (mcand),
    .mplier_in   (mplier),
    .next_result (next_result)
  );

  always_ff @(posedge clk) begin
    if (rst) product_q <= '0;
    else if (last) product_q <= next_result;
  end

  assign product = product_q;

endmodule

// File: rtl/booth_seq_mul_chk.sv
module booth_seq_mul_chk #(
  parameter int WIDTH = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic [WIDTH-1:0]   mcand,
  input logic [WIDTH-1:0]   mplier,
  input logic               busy,
  input logic               done,
  input logic [2*WIDTH-1:0] product
);
  localparam int RW = $clog2(WIDTH + 1) + 1;

  logic [RW-1:0] run_len;
  logic signed [2*WIDTH-1:0] cap_a, cap_b, expect_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len <= '0;
      cap_a   <= '0;
      cap_b   <= '0;
    end else begin
      run_len <= busy ? run_len + 1'b1 : '0;
      if (start && !busy) begin
        cap_a <= {{WIDTH{mcand[WIDTH-1]}}, mcand};
        cap_b <= {{WIDTH{mplier[WIDTH-1]}}, mplier};
      end
    end
  end

  assign expect_p = cap_a * cap_b;

  // R2: an accepted start makes busy high next cycle
  a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  // R2: busy never outlasts WIDTH cycles
  a_r2_busy_len: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_len < RW'(WIDTH)));
  // R3: done follows exactly WIDTH busy cycles
  a_r3_done_after_run: assert property (@(posedge clk) disable iff (rst)
    done |-> (run_len == RW'(WIDTH)));
  // R3: done is a single-cycle pulse, never with busy
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r3_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R4: result matches the captured operands
  a_r4_product: assert property (@(posedge clk) disable iff (rst)
    done |-> (product == expect_p));
  // R9: product moves only with done
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(product) |-> done);

endmodule

bind booth_seq_mul booth_seq_mul_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/booth_seq_mul_test.sv
module booth_seq_mul_test;
  localparam int W = 32;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst;
  logic start;
  logic [W-1:0] mcand, mplier;
  logic busy, done;
  logic [2*W-1:0] product;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit finished = 1'b0;

  booth_seq_mul #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .start(start), .mcand(mcand), .mplier(mplier),
    .busy(busy), .done(done), .product(product)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [2*W-1:0] ea, eb;
    ea = {{W{a[W-1]}}, a};
    eb = {{W{b[W-1]}}, b};
    return ea * eb;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [2*W-1:0] act,
                       input logic [2*W-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  // One operation; inject: mid-run start with other operands (R7)
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit inject, input string tag);
    int cnt;
    logic [2*W-1:0] held;
    logic [2*W-1:0] exp;
    exp  = ref_mul(a, b);
    held = product;
    @(negedge clk);
    mcand = a; mplier = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mcand = ~a; mplier = b ^ 32'h5A5A_0F0F;   // R8: scramble after capture
    cnt = 0;
    while (!done) begin
      if (busy) cnt++;
      if (cnt == 3)
        check(product == held, "R9 product held during run", product, held);
      if (inject && cnt == 5) start = 1'b1;
      else start = 1'b0;
      if (inject && cnt == 5) begin mcand = 32'h1234_5678; mplier = 32'h8000_0001; end
      if (cnt > W + 4) break;
      @(negedge clk);
    end
    start = 1'b0;
    check(cnt == W, {"R2 busy length ", tag}, 2*W'(cnt), 2*W'(W));
    check(!busy, {"R3 busy low with done ", tag}, {{(2*W-1){1'b0}}, busy}, '0);
    check(product == exp, {"R4 product ", tag}, product, exp);
  endtask

  initial begin
    logic [2*W-1:0] snap;
    int unsigned seed;
    seed = $urandom(32'd20240611);
    rst = 1'b1; start = 1'b0; mcand = '0; mplier = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && product == '0, "R1 reset state", product, '0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && product == '0, "R1 after release", product, '0);

    run_op(32'd2, 32'hFFFF_FFFD, 0, "R4 2*-3");
    check(product == 64'hFFFF_FFFF_FFFF_FFFA, "R4 2*-3 is -6", product, 64'hFFFF_FFFF_FFFF_FFFA);
    @(negedge clk);
    check(!done, "R3 done one cycle", {63'd0, done}, '0);

    run_op(32'h8000_0000, 32'h8000_0000, 0, "R6 min*min");
    check(product == 64'h4000_0000_0000_0000, "R6 min*min value", product, 64'h4000_0000_0000_0000);
    run_op(32'h8000_0000, 32'h7FFF_FFFF, 0, "R6 min*max");
    run_op(32'h7FFF_FFFF, 32'h8000_0000, 0, "R6 max*min");
    run_op(32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, "R5 max*max");
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R5 -1*-1");
    run_op(32'h0000_0000, 32'hDEAD_BEEF, 0, "R4 zero");
    run_op(32'h1357_9BDF, 32'hAAAA_AAAA, 0, "R5 alt10");
    run_op(32'hF00D_CAFE, 32'h5555_5555, 0, "R5 alt01");
    run_op(32'h0000_0001, 32'h0FFF_FFF0, 0, "R5 run of ones");

    // R7: start while busy is ignored
    run_op(32'h0BAD_F00D, 32'hC0DE_0042, 1, "R7 mid start");
    @(negedge clk);
    check(!busy, "R7 no extra run", {63'd0, busy}, '0);

    // R9: hold through idle with moving inputs
    snap = product;
    repeat (4) begin
      @(negedge clk);
      mcand = $urandom; mplier = $urandom;
    end
    check(product == snap, "R9 product held idle", product, snap);

    // R10: back-to-back start in the done cycle
    run_op(32'd7, 32'd9, 0, "R10 first");
    mcand = 32'hFFFF_FFF9; mplier = 32'd9; start = 1'b1;  // still in done cycle
    @(negedge clk);
    start = 1'b0;
    check(busy, "R10 accepted in done cycle", {63'd0, busy}, 64'd1);
    while (!done) @(negedge clk);
    check(product == ref_mul(32'hFFFF_FFF9, 32'd9), "R10 second result", product,
          ref_mul(32'hFFFF_FFF9, 32'd9));

    for (int i = 0; i < 60; i++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom; rb = $urandom;
      if (i % 7 == 0) rb = {W{1'b1}} << (i % W);
      run_op(ra, rb, (i % 11) == 0, "R4 random");
    end

    finished = 1'b1;
    report();
  end

endmodule